// File: doc/BRIEF.md
# Ternary Match Lookup Table with Result Memory

This block is a small ternary content-addressable lookup table. It holds a fixed number of entries, each made of a stored key, a per-bit care mask and a valid flag. Every cycle the search key on its input is compared against all entries at once. A bit whose care flag is clear is a wildcard and matches either search value. The lowest-numbered valid entry that matches is selected.

The selected index then reads a second memory, the result memory, which holds one programmed word per entry. The block therefore turns a search key directly into a pre-programmed result word, for example a translated address or a next-state and output code. Hit flag, matching index and result word appear one clock after the key is presented. On a miss all three are zero.

Firmware programs the table at run time through two independent write ports: one sets an entry's key, mask and valid flag in a single cycle, the other sets a result word. A write that lands in the same cycle as a search does not affect that search.

Top module: `tcam_lookup`

## Requirements
- R1: Every entry is compared with `srch_key` in parallel. `hit` is 1 exactly when at least one valid entry matched the key, and `hit_idx` gives the number of the selected entry.
- R2: On a hit, `result` equals the word held in the result memory at address `hit_idx`.
- R3: Bit b of an entry matches when its care bit is 0, or when its care bit is 1 and the stored bit equals key bit b. An entry matches only when all of its bits match.
- R4: An entry with stored key 5'b10000 and care mask 5'b11001, read MSB first as 1,0,X,X,0, matches exactly the four keys 5'b10000, 5'b10010, 5'b10100 and 5'b10110, and no other of the 32 keys.
- R5: When no valid entry matches, `hit` is 0, `hit_idx` is 0 and `result` is 0.
- R6: When several valid entries match, the one with the lowest index is selected.
- R7: A cycle with `ent_we` high writes key, care mask and valid flag of entry `ent_idx` together. An entry whose valid flag is 0 never matches, even with an all-zero care mask.
- R8: A key presented before clock edge N is reflected on `hit`, `hit_idx` and `result` after edge N and not before it.
- R9: An entry write or a result write issued in the same cycle as a search is not seen by that search. The search uses the previous contents.
- R10: After reset every entry is invalid, every result word is zero, and the outputs read as a miss.
- R11: A result-memory write with `res_we` high changes the result returned by later lookups that hit that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| srch_key | input | KEY_W | Search key, sampled every cycle |
| ent_we | input | 1 | Entry write strobe |
| ent_idx | input | IDX_W | Entry to write |
| ent_key | input | KEY_W | Stored key for the written entry |
| ent_care | input | KEY_W | Care mask, 1 = bit is compared |
| ent_valid | input | 1 | Valid flag for the written entry |
| res_we | input | 1 | Result memory write strobe |
| res_idx | input | IDX_W | Result memory address |
| res_data | input | RES_W | Result word to write |
| hit | output | 1 | A valid entry matched the key of the previous cycle |
| hit_idx | output | IDX_W | Selected entry index, 0 on a miss |
| result | output | RES_W | Result word of the selected entry, 0 on a miss |

## Verification
The checker assumes that reset is held across at least one rising edge before it is released, and that write addresses stay below the entry count, so the registered view of the table is always well defined. The bench keeps within this: it asserts reset for several cycles and only ever writes indices 0 to ENTRIES-1. It drives keys and write strobes at falling edges, so every search and every write belongs to exactly one cycle. Each sweep runs through all 32 keys of the small default configuration against a bench copy of the table.

// File: rtl/tcam_lookup_pkg.sv
// Package: shared default sizes and the index-width helper for the
// ternary lookup table. Assumes nothing beyond elaboration-time constants.
package tcam_lookup_pkg;

    localparam int DEF_ENTRIES = 8;
    localparam int DEF_KEY_W   = 5;
    localparam int DEF_RES_W   = 8;

    // Width needed to number n items, never below one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tcam_entry_array.sv
// Entry storage and parallel compare. Holds key, care mask and valid flag
// for every entry and produces one match line per entry from the current
// search key. Assumes the write index is below ENTRIES. Any other index
// writes nothing.
module tcam_entry_array #(
    parameter int ENTRIES = 8,
    parameter int KEY_W   = 5,
    parameter int IDX_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [IDX_W-1:0]         widx,
    input  logic [KEY_W-1:0]         wkey,
    input  logic [KEY_W-1:0]         wcare,
    input  logic                     wvalid,
    input  logic [KEY_W-1:0]         srch_key,
    output logic [ENTRIES-1:0]       match_vec,
    output logic [ENTRIES*KEY_W-1:0] key_flat,
    output logic [ENTRIES*KEY_W-1:0] care_flat,
    output logic [ENTRIES-1:0]       valid_vec
);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic [KEY_W-1:0] key_q;
        logic [KEY_W-1:0] care_q;
        logic             valid_q;
        logic             sel;

        assign sel = we && (widx == IDX_W'(e));

        // Entry register: reset clears valid, a write loads all three fields.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                key_q   <= '0;
                care_q  <= '0;
                valid_q <= 1'b0;
            end else if (sel) begin
                key_q   <= wkey;
                care_q  <= wcare;
                valid_q <= wvalid;
            end
        end

        // Match line: every cared bit equal, and the entry valid.
        always_comb begin
            match_vec[e] = valid_q && (((srch_key ^ key_q) & care_q) == '0);
        end

        assign key_flat[e*KEY_W +: KEY_W]  = key_q;
        assign care_flat[e*KEY_W +: KEY_W] = care_q;
        assign valid_vec[e]                = valid_q;
    end

endmodule

// File: rtl/tcam_prio_enc.sv
// Fixed-priority resolver: picks the lowest set bit of the match vector.
// Reports whether any bit is set. The index is 0 when none is.
module tcam_prio_enc #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic [ENTRIES-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    // Scan from the top down so the lowest set bit is written last.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tcam_result_ram.sv
// Result memory: one word per entry, synchronous write, combinational read.
// Reset clears every word. Assumes the write address is below DEPTH.
module tcam_result_ram #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        // Word register: cleared by reset, loaded when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[w] <= '0;
            end else if (we && (widx == IDX_W'(w))) begin
                mem[w] <= wdata;
            end
        end
    end

    // Read port: out-of-range addresses return zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ridx == IDX_W'(i)) rdata = mem[i];
        end
    end

endmodule

// File: rtl/tcam_lookup.sv
// Top of the ternary lookup: entry array, priority resolver and result
// memory, followed by one output register stage. A key presented in one
// cycle yields hit, index and result in the next. Writes take effect at
// the same edge that registers the search, so a search never sees them.
module tcam_lookup #(
    parameter int ENTRIES = tcam_lookup_pkg::DEF_ENTRIES,
    parameter int KEY_W   = tcam_lookup_pkg::DEF_KEY_W,
    parameter int RES_W   = tcam_lookup_pkg::DEF_RES_W,
    localparam int IDX_W  = tcam_lookup_pkg::idx_width(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] srch_key,
    input  logic             ent_we,
    input  logic [IDX_W-1:0] ent_idx,
    input  logic [KEY_W-1:0] ent_key,
    input  logic [KEY_W-1:0] ent_care,
    input  logic             ent_valid,
    input  logic             res_we,
    input  logic [IDX_W-1:0] res_idx,
    input  logic [RES_W-1:0] res_data,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic [RES_W-1:0] result
);

    logic [ENTRIES-1:0]       match_vec;
    logic [ENTRIES*KEY_W-1:0] key_flat;
    logic [ENTRIES*KEY_W-1:0] care_flat;
    logic [ENTRIES-1:0]       valid_vec;
    logic                     any_match;
    logic [IDX_W-1:0]         win_idx;
    logic [RES_W-1:0]         win_data;

    tcam_entry_array #(
        .ENTRIES(ENTRIES),
        .KEY_W  (KEY_W),
        .IDX_W  (IDX_W)
    ) u_entries (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ent_we),
        .widx     (ent_idx),
        .wkey     (ent_key),
        .wcare    (ent_care),
        .wvalid   (ent_valid),
        .srch_key (srch_key),
        .match_vec(match_vec),
        .key_flat (key_flat),
        .care_flat(care_flat),
        .valid_vec(valid_vec)
    );

    tcam_prio_enc #(
        .ENTRIES(ENTRIES),
        .IDX_W  (IDX_W)
    ) u_prio (
        .req(match_vec),
        .any(any_match),
        .idx(win_idx)
    );

    tcam_result_ram #(
        .DEPTH(ENTRIES),
        .WIDTH(RES_W),
        .IDX_W(IDX_W)
    ) u_results (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (res_we),
        .widx (res_idx),
        .wdata(res_data),
        .ridx (win_idx),
        .rdata(win_data)
    );

    // Output stage: capture the resolved lookup, forcing zeros on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit     <= 1'b0;
            hit_idx <= '0;
            result  <= '0;
        end else begin
            hit     <= any_match;
            hit_idx <= any_match ? win_idx : '0;
            result  <= any_match ? win_data : '0;
        end
    end

endmodule

// File: rtl/tcam_lookup_chk.sv
// Checker for tcam_lookup. It keeps a one-cycle copy of the table and of
// the key, then relates the registered outputs to them. Assumes reset is
// held over at least one rising edge before release.
module tcam_lookup_chk #(
    parameter int ENTRIES = 8,
    parameter int KEY_W   = 5,
    parameter int RES_W   = 8,
    parameter int IDX_W   = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [KEY_W-1:0]         srch_key,
    input logic                     hit,
    input logic [IDX_W-1:0]         hit_idx,
    input logic [RES_W-1:0]         result,
    input logic [ENTRIES-1:0]       match_vec,
    input logic [ENTRIES*KEY_W-1:0] key_flat,
    input logic [ENTRIES*KEY_W-1:0] care_flat,
    input logic [ENTRIES-1:0]       valid_vec
);

    logic [KEY_W-1:0]         prev_srch;
    logic [ENTRIES-1:0]       prev_match;
    logic [ENTRIES*KEY_W-1:0] prev_keys;
    logic [ENTRIES*KEY_W-1:0] prev_cares;
    logic [ENTRIES-1:0]       prev_valid;
    logic [KEY_W-1:0]         sel_key;
    logic [KEY_W-1:0]         sel_care;
    logic                     sel_valid;
    logic [ENTRIES-1:0]       below;

    // Snapshot of what the design saw one cycle earlier.
    always_ff @(posedge clk) begin
        prev_srch  <= srch_key;
        prev_match <= match_vec;
        prev_keys  <= key_flat;
        prev_cares <= care_flat;
        prev_valid <= valid_vec;
    end

    // Fields of the reported entry, and the mask of lower-numbered entries.
    always_comb begin
        sel_key   = prev_keys[int'(hit_idx)*KEY_W +: KEY_W];
        sel_care  = prev_cares[int'(hit_idx)*KEY_W +: KEY_W];
        sel_valid = prev_valid[hit_idx];
        below     = (ENTRIES'(1) << hit_idx) - ENTRIES'(1);
    end

    // R1: hit follows whether any entry matched the previous key.
    p_hit_any_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hit == (|prev_match));

    // R3 / R7: a reported entry was valid and agreed on every cared bit.
    p_masked_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (sel_valid && (((prev_srch ^ sel_key) & sel_care) == '0)));

    // R5: a miss reads as all zeros.
    p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_idx == '0 && result == '0));

    // R6: the reported entry matched and no lower entry did.
    p_lowest_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (prev_match[hit_idx] && ((prev_match & below) == '0)));

endmodule

bind tcam_lookup tcam_lookup_chk #(
    .ENTRIES(ENTRIES),
    .KEY_W  (KEY_W),
    .RES_W  (RES_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .srch_key (srch_key),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .result   (result),
    .match_vec(match_vec),
    .key_flat (key_flat),
    .care_flat(care_flat),
    .valid_vec(valid_vec)
);

// File: tb/tcam_lookup_test.sv
// Bench: sweeps all keys of the default table against a bench copy of it.
module tcam_lookup_test;

    localparam int ENTRIES = 8;
    localparam int KEY_W   = 5;
    localparam int RES_W   = 8;
    localparam int IDX_W   = 3;
    localparam int NKEYS   = 1 << KEY_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [KEY_W-1:0] srch_key = '0;
    logic             ent_we = 1'b0;
    logic [IDX_W-1:0] ent_idx = '0;
    logic [KEY_W-1:0] ent_key = '0;
    logic [KEY_W-1:0] ent_care = '0;
    logic             ent_valid = 1'b0;
    logic             res_we = 1'b0;
    logic [IDX_W-1:0] res_idx = '0;
    logic [RES_W-1:0] res_data = '0;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic [RES_W-1:0] result;

    int checks = 0;
    int fails  = 0;

    logic [KEY_W-1:0] m_key  [ENTRIES];
    logic [KEY_W-1:0] m_care [ENTRIES];
    logic             m_val  [ENTRIES];
    logic [RES_W-1:0] m_res  [ENTRIES];

    always #10 clk = ~clk;

    tcam_lookup #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .RES_W(RES_W)) uut (
        .clk(clk), .rst_n(rst_n), .srch_key(srch_key),
        .ent_we(ent_we), .ent_idx(ent_idx), .ent_key(ent_key),
        .ent_care(ent_care), .ent_valid(ent_valid),
        .res_we(res_we), .res_idx(res_idx), .res_data(res_data),
        .hit(hit), .hit_idx(hit_idx), .result(result)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // Lowest valid entry whose cared bits equal the key.
    task automatic model(input logic [KEY_W-1:0] k, output logic eh,
                         output logic [IDX_W-1:0] ei, output logic [RES_W-1:0] er);
        eh = 1'b0; ei = '0; er = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (m_val[i] && (((k ^ m_key[i]) & m_care[i]) == '0)) begin
                eh = 1'b1; ei = IDX_W'(i); er = m_res[i];
            end
        end
    endtask

    // Present a key at a falling edge and check one cycle later.
    task automatic lookup(input logic [KEY_W-1:0] k, input string rq);
        logic eh; logic [IDX_W-1:0] ei; logic [RES_W-1:0] er;
        model(k, eh, ei, er);
        srch_key = k;
        @(negedge clk);
        check({rq, " hit"}, 32'(hit), 32'(eh));
        check({rq, " idx"}, 32'(hit_idx), 32'(ei));
        check({rq, " result"}, 32'(result), 32'(er));
    endtask

    task automatic sweep(input string rq);
        for (int k = 0; k < NKEYS; k++) lookup(KEY_W'(k), rq);
    endtask

    task automatic write_entry(input int i, input logic [KEY_W-1:0] k,
                               input logic [KEY_W-1:0] c, input logic v);
        ent_we = 1'b1; ent_idx = IDX_W'(i); ent_key = k; ent_care = c; ent_valid = v;
        @(negedge clk);
        ent_we = 1'b0;
        m_key[i] = k; m_care[i] = c; m_val[i] = v;
    endtask

    task automatic write_res(input int i, input logic [RES_W-1:0] d);
        res_we = 1'b1; res_idx = IDX_W'(i); res_data = d;
        @(negedge clk);
        res_we = 1'b0;
        m_res[i] = d;
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        int nhit;
        for (int i = 0; i < ENTRIES; i++) begin
            m_key[i] = '0; m_care[i] = '0; m_val[i] = 1'b0; m_res[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state reads as a miss for every key.
        check("R10 hit", 32'(hit), 0);
        check("R10 result", 32'(result), 0);
        sweep("R10");

        // R7: an invalid entry with an all-wildcard mask never matches.
        write_entry(4, 5'b00000, 5'b00000, 1'b0);
        write_res(4, 8'hEE);
        sweep("R7 invalid");

        // R4: pattern 1,0,X,X,0 hits exactly four keys.
        write_entry(2, 5'b10000, 5'b11001, 1'b1);
        write_res(2, 8'h5C);
        nhit = 0;
        for (int k = 0; k < NKEYS; k++) begin
            srch_key = KEY_W'(k);
            @(negedge clk);
            check("R4 hit", 32'(hit), 32'((k & 5'b11001) == 5'b10000));
            check("R2 result", 32'(result), ((k & 5'b11001) == 5'b10000) ? 32'h5C : 0);
            if (hit) nhit++;
        end
        check("R4 count", 32'(nhit), 4);

        // R1 / R3 / R6: overlapping entries with assorted masks.
        write_entry(0, 5'b11111, 5'b11111, 1'b1); write_res(0, 8'h22);
        write_entry(1, 5'b00000, 5'b00000, 1'b1); write_res(1, 8'h11);
        write_entry(5, 5'b01010, 5'b01110, 1'b1); write_res(5, 8'h55);
        sweep("R6 wildcard at 1");
        lookup(5'b11111, "R6 lowest");
        check("R6 idx zero", 32'(hit_idx), 0);

        // R7: invalidating the wildcard exposes higher entries.
        write_entry(1, 5'b00000, 5'b00000, 1'b0);
        sweep("R3 after clear");
        lookup(5'b10110, "R3 care");
        check("R3 entry 2", 32'(hit_idx), 2);

        // R8: output does not change before the edge.
        lookup(5'b00001, "R8 miss");
        srch_key = 5'b11111;
        #2;
        check("R8 before edge", 32'(hit), 0);
        @(negedge clk);
        check("R8 after edge", 32'(hit), 1);
        check("R8 result", 32'(result), 32'h22);

        // R9: same-cycle writes are not seen by the search.
        srch_key = 5'b11111;
        ent_we = 1'b1; ent_idx = 0; ent_key = 5'b00011; ent_care = 5'b11111; ent_valid = 1'b1;
        res_we = 1'b1; res_idx = 0; res_data = 8'h99;
        @(negedge clk);
        ent_we = 1'b0; res_we = 1'b0;
        check("R9 old hit", 32'(hit), 1);
        check("R9 old idx", 32'(hit_idx), 0);
        check("R9 old result", 32'(result), 32'h22);
        m_key[0] = 5'b00011; m_res[0] = 8'h99;
        lookup(5'b11111, "R9 new");
        check("R9 gone", 32'(hit), 0);

        // R11: result rewrite changes later hits.
        lookup(5'b00011, "R11 before");
        write_res(0, 8'h3A);
        lookup(5'b00011, "R11 after");
        check("R11 value", 32'(result), 32'h3A);
        sweep("R1 final");

        report();
        $finish;
    end

endmodule